// File: doc/BRIEF.md
# Processor Identification Leaf Responder

This block answers identification queries the way a processor's identify instruction does. A query carries a 32-bit leaf selector. One clock after the block accepts the query, it returns four 32-bit words A, B, C and D. The standard range gives three kinds of answer: the vendor text, the signature with its companion word and feature flags, and a constant descriptor leaf. The extended range, selected by bit 31, gives the highest extended leaf, an extended feature word and a 48-character product name. A second range starting at 0xC0000000 announces that the identity is programmable and mirrors the extended results.

Software can program a substitute vendor text and a substitute signature through a small write port. One control bit chooses between the substitute vendor and the true vendor. The signature has no such choice: once it is rewritten it stays rewritten until reset. A second control bit enables execution. When that bit is clear, every query returns an invalid-operation fault instead of data.

Queries use a valid/ready handshake and so do responses. The block holds one response register. It accepts a new query only while that register is empty, or while the register is being drained in the same cycle (`req_ready = !rsp_valid || rsp_ready`). While `rsp_ready` is low, the pending response stays unchanged and no new query is taken. Configuration writes take effect at the clock edge on which they are presented. A query accepted on that same edge still sees the earlier configuration.

Top module: `ident_leaf_unit`

## Requirements
- R1: A query accepted on an edge (`req_valid && req_ready`) produces `rsp_valid` one clock later. `req_ready` equals `!rsp_valid || rsp_ready`. A response that is not taken holds all of its outputs. A taken response with no new query clears `rsp_valid`.
- R2: Leaf 0 returns A = 2, the highest standard leaf. The 12-character vendor text is spread over B, then D, then C, four characters per word, with the earliest character in bits [7:0] of each word. Character 0 sits in B[7:0] and character 11 in C[31:24].
- R3: Leaf 1 returns A = {16'h0, signature}. The signature is laid out as stepping [3:0], model [7:4], family [11:8] and type [15:12]. B holds the companion word (APIC ID [31:24], logical count [23:16], flush line size [15:8], brand [7:0]), C = 0 and D holds the feature flags.
- R4: A query with bit 31 clear and a value above 2 returns A equal to the selector and B = C = D = 0.
- R5: Leaf 0x80000000 returns A = 0x80000004, the highest extended leaf. Leaf 0x80000001 returns the extended feature word in D, with A, B and C at 0.
- R6: Leaves 0x80000002 to 0x80000004 return the 48-byte name, 16 bytes per leaf, in the order A, B, C, D with the low byte first. Byte n of leaf 0x80000002+k is name character 16k+n. Every position past the end of the name reads zero.
- R7: Leaf 0xC0000000 returns A = 0xC0000000 and B = C = D = 0. Leaves 0xC0000001 to 0xC0000004 return the same words as 0x80000001 to 0x80000004.
- R8: Write address 0, 1 and 2 load the substitute vendor words shown in B, D and C. Address 3 loads the signature from data [15:0]. While control bit 14 is set, leaf 0 shows the substitute text and leaf 1 shows the written signature.
- R9: Writing the control word (address 4) with bit 14 clear makes leaf 0 show the true vendor. Leaf 1 keeps showing the written signature. Setting bit 14 again brings the substitute text back.
- R10: With control bit 7 clear, every response has `rsp_fault` = 1 and A = B = C = D = 0.
- R11: After reset, `rsp_valid` = 0 and `req_ready` = 1. The substitute vendor and signature equal the true ones. Control bits 14 and 7 are both 1.
- R12: Extended and mirror selectors whose low 30 bits are above 4 return all four words as zero with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Query present |
| req_ready | output | 1 | Block can take a query this cycle |
| req_leaf | input | 32 | Leaf selector |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | Execution disabled; data words are zero |
| rsp_a | output | 32 | Result word A |
| rsp_b | output | 32 | Result word B |
| rsp_c | output | 32 | Result word C |
| rsp_d | output | 32 | Result word D |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | 0-2 vendor words (B, D, C), 3 signature, 4 control |
| cfg_wdata | input | 32 | Write data; control bit 14 selects the substitute vendor, bit 7 enables |

## Verification
The assertions check the handshake on every cycle: the one-clock latency, holding under back-pressure and the drop of `rsp_valid` once the response is taken. They also check the properties that follow from the selector alone: the echo of unsupported standard leaves, the zero upper signature half, the 0xC0000000 tag, zero words beyond the extended top and all-zero data on a fault. The vendor text order, the name bytes, the mirror equality and the interplay of substitute writes, the vendor control bit, the sticky signature and reset depend on earlier writes. Those only the bench's scenarios can show, by comparing against its own model.

// File: rtl/ident_pkg.sv
package ident_pkg;
  localparam int STD_TOP    = 2;
  localparam int NAME_BYTES = 48;
  localparam int VEND_BYTES = 12;
  localparam int KEEP_BIT   = 14;
  localparam int EN_BIT     = 7;

  typedef enum logic [2:0] {
    CFG_VEND_B = 3'd0,
    CFG_VEND_D = 3'd1,
    CFG_VEND_C = 3'd2,
    CFG_SIG    = 3'd3,
    CFG_CTRL   = 3'd4
  } cfg_addr_e;

  typedef struct packed {
    logic        fault;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    logic [31:0] d;
  } ident_rsp_t;
endpackage

// File: rtl/ident_cfg_regs.sv
module ident_cfg_regs
  import ident_pkg::*;
#(
  parameter logic [8*VEND_BYTES-1:0] TRUE_VENDOR = "ProgIdentCPU",
  parameter logic [15:0]             TRUE_SIG    = 16'h0541
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [2:0][31:0] vend_eff,
  output logic [15:0]      sig,
  output logic             enable
);
  logic [2:0][31:0] true_w;
  logic [2:0][31:0] sub_w;
  logic             keep_sub;

  for (genvar w = 0; w < 3; w++) begin : g_true
    for (genvar j = 0; j < 4; j++) begin : g_byte
      assign true_w[w][8*j +: 8] = TRUE_VENDOR[8*(VEND_BYTES-1-(4*w+j)) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_w    <= true_w;
      sig      <= TRUE_SIG;
      keep_sub <= 1'b1;
      enable   <= 1'b1;
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_VEND_B: sub_w[0] <= cfg_wdata;
        CFG_VEND_D: sub_w[1] <= cfg_wdata;
        CFG_VEND_C: sub_w[2] <= cfg_wdata;
        CFG_SIG:    sig      <= cfg_wdata[15:0];
        CFG_CTRL: begin
          keep_sub <= cfg_wdata[KEEP_BIT];
          enable   <= cfg_wdata[EN_BIT];
        end
        default: ;
      endcase
    end
  end

  assign vend_eff = keep_sub ? sub_w : true_w;
endmodule

// File: rtl/ident_leaf_decode.sv
module ident_leaf_decode
  import ident_pkg::*;
#(
  parameter logic [31:0] CACHE_A   = 32'h0403_0201,
  parameter logic [31:0] MISC_B    = 32'h0001_0800,
  parameter logic [31:0] FEATURES  = 32'h0383_F9FF,
  parameter logic [31:0] EXT_FEAT  = 32'h0000_0800,
  parameter int          EXT_COUNT = 4,
  parameter int          NAME_LEN  = 20,
  parameter logic [8*NAME_LEN-1:0] NAME_STR = "Programmable ID Core"
) (
  input  logic [31:0]      leaf,
  input  logic             enable,
  input  logic [2:0][31:0] vend,
  input  logic [15:0]      sig,
  output ident_rsp_t       rsp
);
  logic [NAME_BYTES-1:0][7:0] name_b;

  for (genvar k = 0; k < NAME_BYTES; k++) begin : g_name
    if (k < NAME_LEN) begin : g_chr
      assign name_b[k] = NAME_STR[8*(NAME_LEN-1-k) +: 8];
    end else begin : g_nul
      assign name_b[k] = 8'h00;
    end
  end

  logic [1:0]       chunk;
  logic [3:0][31:0] name_w;
  assign chunk = leaf[1:0] - 2'd2;

  always_comb begin
    for (int r = 0; r < 4; r++) begin
      for (int j = 0; j < 4; j++) begin
        name_w[r][8*j +: 8] = name_b[int'(chunk)*16 + r*4 + j];
      end
    end
  end

  always_comb begin
    rsp = '0;
    if (!enable) begin
      rsp.fault = 1'b1;
    end else if (!leaf[31]) begin
      case (leaf)
        32'd0: begin
          rsp.a = 32'(STD_TOP);
          rsp.b = vend[0];
          rsp.d = vend[1];
          rsp.c = vend[2];
        end
        32'd1: begin
          rsp.a = {16'h0000, sig};
          rsp.b = MISC_B;
          rsp.d = FEATURES;
        end
        32'd2:   rsp.a = CACHE_A;
        default: rsp.a = leaf;
      endcase
    end else if (leaf[30] && leaf[29:0] == 30'd0) begin
      rsp.a = 32'hC000_0000;
    end else if (leaf[29:3] == 27'd0 && int'(leaf[2:0]) <= EXT_COUNT) begin
      case (leaf[2:0])
        3'd0: rsp.a = (EXT_COUNT == 0) ? 32'h0 : (32'h8000_0000 | 32'(EXT_COUNT));
        3'd1: rsp.d = EXT_FEAT;
        3'd2, 3'd3, 3'd4: begin
          rsp.a = name_w[0];
          rsp.b = name_w[1];
          rsp.c = name_w[2];
          rsp.d = name_w[3];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ident_rsp_stage.sv
module ident_rsp_stage
  import ident_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  ident_rsp_t in_rsp,
  output logic       out_valid,
  input  logic       out_ready,
  output ident_rsp_t out_rsp
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rsp   <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_rsp   <= in_rsp;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ident_leaf_unit.sv
module ident_leaf_unit
  import ident_pkg::*;
#(
  parameter logic [8*VEND_BYTES-1:0] TRUE_VENDOR = "ProgIdentCPU",
  parameter logic [15:0]             TRUE_SIG    = 16'h0541,
  parameter logic [31:0]             CACHE_A     = 32'h0403_0201,
  parameter logic [31:0]             MISC_B      = 32'h0001_0800,
  parameter logic [31:0]             FEATURES    = 32'h0383_F9FF,
  parameter logic [31:0]             EXT_FEAT    = 32'h0000_0800,
  parameter int                      EXT_COUNT   = 4,
  parameter int                      NAME_LEN    = 20,
  parameter logic [8*NAME_LEN-1:0]   NAME_STR    = "Programmable ID Core"
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_leaf,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_fault,
  output logic [31:0] rsp_a,
  output logic [31:0] rsp_b,
  output logic [31:0] rsp_c,
  output logic [31:0] rsp_d,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata
);
  logic [2:0][31:0] vend_eff;
  logic [15:0]      sig;
  logic             enable;
  ident_rsp_t       next_rsp;
  ident_rsp_t       held_rsp;

  ident_cfg_regs #(
    .TRUE_VENDOR(TRUE_VENDOR),
    .TRUE_SIG   (TRUE_SIG)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .vend_eff (vend_eff),
    .sig      (sig),
    .enable   (enable)
  );

  ident_leaf_decode #(
    .CACHE_A  (CACHE_A),
    .MISC_B   (MISC_B),
    .FEATURES (FEATURES),
    .EXT_FEAT (EXT_FEAT),
    .EXT_COUNT(EXT_COUNT),
    .NAME_LEN (NAME_LEN),
    .NAME_STR (NAME_STR)
  ) u_decode (
    .leaf  (req_leaf),
    .enable(enable),
    .vend  (vend_eff),
    .sig   (sig),
    .rsp   (next_rsp)
  );

  ident_rsp_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_rsp   (next_rsp),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_rsp  (held_rsp)
  );

  assign rsp_fault = held_rsp.fault;
  assign rsp_a     = held_rsp.a;
  assign rsp_b     = held_rsp.b;
  assign rsp_c     = held_rsp.c;
  assign rsp_d     = held_rsp.d;
endmodule

// File: rtl/ident_leaf_unit_checker.sv
module ident_leaf_unit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_leaf,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_fault,
  input logic [31:0] rsp_a,
  input logic [31:0] rsp_b,
  input logic [31:0] rsp_c,
  input logic [31:0] rsp_d
);
  logic accept;
  assign accept = req_valid && req_ready;

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_a)
      && $stable(rsp_b) && $stable(rsp_c) && $stable(rsp_d))); // R1
  AST_RSP_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !accept) |=> !rsp_valid); // R1
  AST_LEAF0_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_leaf == 32'd0) |=> (rsp_fault || rsp_a == 32'd2)); // R2
  AST_SIG_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_leaf == 32'd1) |=> (rsp_a[31:16] == 16'h0 && rsp_c == 32'h0)); // R3
  AST_STD_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_leaf[31] && req_leaf > 32'd2) |=>
      (rsp_fault || (rsp_a == $past(req_leaf) && rsp_b == 32'h0 && rsp_c == 32'h0 && rsp_d == 32'h0))); // R4
  AST_ALT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_leaf == 32'hC000_0000) |=> (rsp_fault || rsp_a == 32'hC000_0000)); // R7
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_a == 32'h0 && rsp_b == 32'h0 && rsp_c == 32'h0 && rsp_d == 32'h0)); // R10
  AST_EXT_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_leaf[31] && req_leaf[29:0] > 30'd4) |=>
      (rsp_fault || (rsp_a == 32'h0 && rsp_b == 32'h0 && rsp_c == 32'h0 && rsp_d == 32'h0))); // R12
endmodule

bind ident_leaf_unit ident_leaf_unit_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_leaf (req_leaf),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_fault(rsp_fault),
  .rsp_a    (rsp_a),
  .rsp_b    (rsp_b),
  .rsp_c    (rsp_c),
  .rsp_d    (rsp_d)
);

// File: tb/ident_leaf_unit_test.sv
module ident_leaf_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] T_CACHE = 32'h0403_0201;
  localparam logic [31:0] T_MISC  = 32'h0001_0800;
  localparam logic [31:0] T_FEAT  = 32'h0383_F9FF;
  localparam logic [31:0] T_EXTF  = 32'h0000_0800;
  localparam logic [15:0] T_SIG   = 16'h0541;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_leaf = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_fault;
  logic [31:0] rsp_a, rsp_b, rsp_c, rsp_d;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;

  int checks = 0;
  int fails = 0;

  string true_v = "ProgIdentCPU";
  string name_s = "Programmable ID Core";
  logic [31:0] m_sub [3];
  logic [15:0] m_sig;
  bit m_keep, m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  ident_leaf_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_leaf(req_leaf), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_a(rsp_a), .rsp_b(rsp_b), .rsp_c(rsp_c),
    .rsp_d(rsp_d), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  function automatic logic [31:0] str_word(string s, int w);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[8*j +: 8] = byte'(s[4*w+j]);
    return r;
  endfunction

  function automatic logic [7:0] name_chr(int k);
    return (k < name_s.len()) ? byte'(name_s[k]) : 8'h00;
  endfunction

  // expected {fault, a, b, c, d}
  function automatic logic [128:0] model(logic [31:0] leaf);
    logic [31:0] a, b, c, d;
    logic [31:0] off;
    a = 0; b = 0; c = 0; d = 0;
    if (!m_en) return {1'b1, 128'h0};
    if (!leaf[31]) begin
      if (leaf == 0) begin
        a = 2;
        b = m_keep ? m_sub[0] : str_word(true_v, 0);
        d = m_keep ? m_sub[1] : str_word(true_v, 1);
        c = m_keep ? m_sub[2] : str_word(true_v, 2);
      end else if (leaf == 1) begin
        a = {16'h0, m_sig}; b = T_MISC; d = T_FEAT;
      end else if (leaf == 2) a = T_CACHE;
      else a = leaf;
    end else begin
      off = {2'b00, leaf[29:0]};
      if (leaf[30] && off == 0) a = 32'hC000_0000;
      else if (off == 0) a = 32'h8000_0004;
      else if (off == 1) d = T_EXTF;
      else if (off <= 4) begin
        for (int j = 0; j < 4; j++) begin
          a[8*j +: 8] = name_chr(16*(int'(off)-2) + j);
          b[8*j +: 8] = name_chr(16*(int'(off)-2) + 4 + j);
          c[8*j +: 8] = name_chr(16*(int'(off)-2) + 8 + j);
          d[8*j +: 8] = name_chr(16*(int'(off)-2) + 12 + j);
        end
      end
    end
    return {1'b0, a, b, c, d};
  endfunction

  task automatic check(string tag, logic [128:0] got, logic [128:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < 3; w++) m_sub[w] = str_word(true_v, w);
    m_sig = T_SIG; m_keep = 1; m_en = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0; cfg_we = 0; rsp_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic cfg_write(logic [2:0] addr, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 0;
    case (addr)
      3'd0, 3'd1, 3'd2: m_sub[addr] = data;
      3'd3: m_sig = data[15:0];
      3'd4: begin m_keep = data[14]; m_en = data[7]; end
      default: ;
    endcase
  endtask

  task automatic query(logic [31:0] leaf, string tag);
    @(negedge clk);
    req_valid = 1; req_leaf = leaf;
    @(negedge clk);
    req_valid = 0;
    check({tag, " valid"}, {128'h0, rsp_valid}, {128'h0, 1'b1});
    check(tag, {rsp_fault, rsp_a, rsp_b, rsp_c, rsp_d}, model(leaf));
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [31:0] pick_leaf();
    case ($urandom % 5)
      0: return $urandom % 6;
      1: return $urandom;
      2: return 32'h8000_0000 | ($urandom % 8);
      3: return 32'hC000_0000 | ($urandom % 8);
      default: return {1'b1, $urandom % 2 == 0, 30'($urandom)};
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [128:0] first;
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();
    @(negedge clk);
    check("R11 reset valid/ready", {127'h0, rsp_valid, req_ready}, {127'h0, 2'b01});
    query(32'd0, "R2 R11 leaf0 true vendor");
    query(32'd1, "R3 R11 leaf1 true signature");
    query(32'd2, "R3 leaf2 descriptor");
    query(32'd3, "R4 echo leaf3");
    query(32'h4000_0007, "R4 echo bit30");
    query(32'h8000_0000, "R5 ext top");
    query(32'h8000_0001, "R5 ext features");
    query(32'h8000_0002, "R6 name chunk0");
    query(32'h8000_0003, "R6 name chunk1");
    query(32'h8000_0004, "R6 name chunk2");
    query(32'h8000_0005, "R12 beyond ext");
    query(32'h8000_1002, "R12 high offset");
    query(32'hC000_0000, "R7 alt tag");
    query(32'hC000_0003, "R7 alt mirror");
    query(32'hC000_0006, "R12 alt beyond");

    cfg_write(3'd0, str_word("FakeVendorXY", 0));
    cfg_write(3'd1, str_word("FakeVendorXY", 1));
    cfg_write(3'd2, str_word("FakeVendorXY", 2));
    cfg_write(3'd3, 32'hABCD_1234);
    query(32'd0, "R8 substitute vendor");
    query(32'd1, "R8 written signature");
    cfg_write(3'd4, 32'h0000_0080);
    query(32'd0, "R9 true vendor restored");
    query(32'd1, "R9 signature sticky");
    cfg_write(3'd4, 32'h0000_4080);
    query(32'd0, "R9 substitute back");
    cfg_write(3'd4, 32'h0000_4000);
    query(32'd0, "R10 disabled leaf0");
    query(32'h8000_0002, "R10 disabled name");
    cfg_write(3'd4, 32'h0000_4080);

    // back-pressure
    rsp_ready = 0;
    @(negedge clk); req_valid = 1; req_leaf = 32'd0;
    @(negedge clk);
    first = model(32'd0);
    req_leaf = 32'd1;
    check("R1 ready low while held", {128'h0, req_ready}, 129'h0);
    @(negedge clk);
    check("R1 held response", {rsp_valid, rsp_a, rsp_b, rsp_c, rsp_d}, {1'b1, first[127:0]});
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R1 second after drain", {rsp_fault, rsp_a, rsp_b, rsp_c, rsp_d}, model(32'd1));
    @(negedge clk);
    check("R1 valid drops", {128'h0, rsp_valid}, 129'h0);

    for (int i = 0; i < 400; i++) begin
      if ($urandom % 10 == 0) begin
        if ($urandom % 3 == 0)
          cfg_write(3'd4, {17'h0, 1'($urandom), 6'h0, ($urandom % 4) != 0, 7'h0});
        else
          cfg_write(3'($urandom % 4), $urandom);
      end
      query(pick_leaf(), "R2 R4 R5 R6 R7 R12 random");
    end

    cfg_write(3'd3, 32'h0000_7777);
    do_reset();
    query(32'd1, "R11 signature after reset");
    query(32'd0, "R11 vendor after reset");
    finish_up();
  end
endmodule